// File: doc/BRIEF.md
# Ethernet Transmit Framer for MII and RMII

This block turns the payload of one Ethernet frame into the symbol stream a PHY expects on its transmit pins. Payload bytes arrive over a valid/ready byte stream, and the final byte is marked with a last flag. The block puts the preamble and the start-of-frame delimiter in front of the payload. When hardware CRC is enabled, it adds a four-byte frame check sequence after the payload. Every byte goes out least significant bit first. On MII a byte is sent as two nibbles. On RMII a byte is sent as four dibits.

The block runs on the transmit interface clock. On MII, and on RMII at 100 Mbps, every clock carries a new symbol. On RMII at 10 Mbps, the 50 MHz clock carries a new dibit only once every ten cycles, and each dibit is held for that whole interval.

A frame cannot be paused once the preamble has started. The source must therefore keep up. If the next payload byte is due and the source has none, the frame is cut short and an underrun flag is raised.

Back-pressure follows these rules. A byte transfers on a clock edge where `in_valid` and `in_ready` are both high. Once the source raises `in_valid`, it holds `in_valid`, `in_data` and `in_last` steady until the byte is taken. A frame is started by `in_valid` rising while the block is idle. The block does not take the first byte until the delimiter has been sent. During a frame, `in_ready` is high only in the cycle where the next byte is due. After an underrun, `in_ready` stays high so that the rest of the broken frame can be drained.

Top module: `eth_tx_framer`

## Requirements
- R1: After reset, `tx_en`, `txd`, `underrun` and `in_ready` are all 0.
- R2: Each frame goes out in this order: seven 0x55 bytes, one 0xD5 byte, then the payload bytes in the order they were accepted.
- R3: Each byte is sent least significant bit first. On MII, `txd[3:0]` carries the low nibble and then the high nibble. On RMII, `txd[1:0]` carries bit pairs [1:0], [3:2], [5:4] and [7:6] in that order, and `txd[3:2]` stays 0.
- R4: With hardware CRC on, four FCS bytes follow the payload, lowest byte first. The FCS is the reflected CRC-32 with polynomial 0xEDB88320, initial value all ones and a final inversion. For the payload "123456789" the FCS bytes are 26 39 F4 CB. With hardware CRC off, the frame ends at the last payload byte.
- R5: On MII at either speed, and on RMII at 100 Mbps, a new symbol appears on every clock. On RMII at 10 Mbps, a new symbol appears every 10 clocks. `tx_en` stays high for exactly (number of symbols) × (symbol period) clocks.
- R6: `in_ready` is 0 while idle and during the preamble and delimiter. Across a complete frame, exactly one byte transfers per payload byte.
- R7: If `in_valid` is low when a payload byte is due, that symbol slot is not sent. `tx_en` and `txd` go to 0 on the next clock, and `underrun` goes to 1. Every symbol sent before that point is correct for the frame.
- R8: After an underrun, the block accepts and discards bytes up to and including the one marked last, and then returns to idle. `underrun` stays 1 until the next frame starts.
- R9: The mode, speed and CRC-enable inputs are captured when a frame starts. Changes to them during the frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte is valid; while idle, also requests a new frame |
| in_last | input | 1 | Marks the final payload byte of the frame |
| in_ready | output | 1 | Block takes `in_data` on this edge |
| crc_en | input | 1 | Append the hardware FCS (captured at frame start) |
| rmii_mode | input | 1 | 1 = RMII dibits, 0 = MII nibbles (captured at frame start) |
| speed_100 | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps (captured at frame start) |
| txd | output | 4 | Transmit data symbol |
| tx_en | output | 1 | Transmit enable |
| underrun | output | 1 | The current or previous frame was aborted because the source was starved |

## Verification
The bench rebuilds every frame from `txd` by sampling once per symbol period from the first cycle `tx_en` is high, and compares the result with a reference built from the payload.

The following errors are targeted:
- A swapped nibble or dibit order, which breaks every byte.
- A wrong pacing divider, which changes the number of high cycles of `tx_en`.
- A CRC built with the wrong seed, the wrong polynomial, no final inversion or the wrong byte order. This fails against the "123456789" check value.

Starvation is forced partway through the payload. The bench expects the frame to be cut exactly at the starved symbol slot, then expects the rest of the frame to drain and the flag to clear on the next frame. The configuration inputs are flipped mid-frame, and any leak of those changes into the running frame would corrupt its symbols.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD,
    ST_DATA,
    ST_FCS,
    ST_DONE,
    ST_FLUSH
  } tx_state_e;

  localparam logic [7:0]  PRE_BYTE = 8'h55;
  localparam logic [7:0]  SFD_BYTE = 8'hD5;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam int          FCS_BYTES = 4;

endpackage

// File: rtl/tx_pacer.sv
module tx_pacer #(
  parameter int SLOW_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync,
  input  logic slow,
  output logic tick
);
  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] WRAP = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = !slow || (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (sync || !slow)     cnt <= '0;
    else if (cnt == WRAP)       cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dibit,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       advance,
  output logic [3:0] sym,
  output logic       at_last
);
  logic [7:0] sr;
  logic [1:0] idx;

  assign sym     = dibit ? {2'b00, sr[1:0]} : sr[3:0];
  assign at_last = dibit ? (idx == 2'd3) : (idx == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr  <= '0;
      idx <= '0;
    end else if (load) begin
      sr  <= load_byte;
      idx <= '0;
    end else if (advance) begin
      sr  <= dibit ? (sr >> 2) : (sr >> 4);
      idx <= idx + 2'd1;
    end
  end

  AST_NIBBLE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (!dibit && !load) |=> (dibit || idx < 2'd2)); // R3

endmodule

// File: rtl/tx_crc32.sv
module tx_crc32
  import eth_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        step,
  input  logic [7:0]  data,
  output logic [31:0] crc_q
);
  logic [31:0] crc_nx;

  always_comb begin
    crc_nx = crc_q;
    for (int b = 0; b < 8; b++) begin
      if (crc_nx[0] ^ data[b]) crc_nx = (crc_nx >> 1) ^ CRC_POLY;
      else                     crc_nx = crc_nx >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= '1;
    else if (init)  crc_q <= '1;
    else if (step)  crc_q <= crc_nx;
  end

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_tx_pkg::*;
#(
  parameter int SLOW_DIV = 10,
  parameter int PRE_LEN  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  input  logic       crc_en,
  input  logic       rmii_mode,
  input  logic       speed_100,
  output logic [3:0] txd,
  output logic       tx_en,
  output logic       underrun
);
  localparam int PCW = $clog2(PRE_LEN + 1);
  localparam logic [PCW-1:0] PRE_LAST = PCW'(PRE_LEN - 1);
  localparam logic [1:0]     FCS_LAST = 2'(FCS_BYTES - 1);

  tx_state_e     state;
  logic          cfg_rmii, cfg_slow, cfg_crc;
  logic [PCW-1:0] pre_cnt;
  logic [1:0]    fcs_cnt;
  logic          last_seen;
  logic [3:0]    txd_q;
  logic          tx_en_q;
  logic          underrun_q;

  logic          tick;
  logic [3:0]    sym;
  logic          at_last;
  logic          sh_load, sh_adv;
  logic [7:0]    sh_byte;
  logic          crc_init, crc_step;
  logic [31:0]   crc_q;
  logic [1:0]    fcs_sel;
  logic [7:0]    fcs_byte;
  logic          due;

  tx_pacer #(.SLOW_DIV(SLOW_DIV)) u_pacer (
    .clk   (clk),
    .rst_n (rst_n),
    .sync  (state == ST_IDLE),
    .slow  (cfg_slow),
    .tick  (tick)
  );

  tx_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .dibit     (cfg_rmii),
    .load      (sh_load),
    .load_byte (sh_byte),
    .advance   (sh_adv),
    .sym       (sym),
    .at_last   (at_last)
  );

  tx_crc32 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (crc_init),
    .step  (crc_step),
    .data  (in_data),
    .crc_q (crc_q)
  );

  assign fcs_sel  = (state == ST_FCS) ? fcs_cnt + 2'd1 : 2'd0;
  assign fcs_byte = ~crc_q[{fcs_sel, 3'b000} +: 8];

  assign due = tick && at_last &&
               ((state == ST_SFD) || (state == ST_DATA && !last_seen));
  assign in_ready = due || (state == ST_FLUSH);

  always_comb begin
    sh_load  = 1'b0;
    sh_adv   = 1'b0;
    sh_byte  = PRE_BYTE;
    crc_init = 1'b0;
    crc_step = 1'b0;
    case (state)
      ST_IDLE: begin
        if (in_valid) begin
          sh_load  = 1'b1;
          crc_init = 1'b1;
        end
      end
      ST_PRE: begin
        if (tick) begin
          if (!at_last) sh_adv = 1'b1;
          else begin
            sh_load = 1'b1;
            sh_byte = (pre_cnt == PRE_LAST) ? SFD_BYTE : PRE_BYTE;
          end
        end
      end
      ST_SFD, ST_DATA: begin
        if (tick) begin
          if (!at_last) sh_adv = 1'b1;
          else if (state == ST_DATA && last_seen) begin
            if (cfg_crc) begin
              sh_load = 1'b1;
              sh_byte = fcs_byte;
            end
          end else if (in_valid) begin
            sh_load  = 1'b1;
            sh_byte  = in_data;
            crc_step = 1'b1;
          end
        end
      end
      ST_FCS: begin
        if (tick) begin
          if (!at_last) sh_adv = 1'b1;
          else if (fcs_cnt != FCS_LAST) begin
            sh_load = 1'b1;
            sh_byte = fcs_byte;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cfg_rmii   <= 1'b0;
      cfg_slow   <= 1'b0;
      cfg_crc    <= 1'b0;
      pre_cnt    <= '0;
      fcs_cnt    <= '0;
      last_seen  <= 1'b0;
      txd_q      <= '0;
      tx_en_q    <= 1'b0;
      underrun_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          tx_en_q <= 1'b0;
          txd_q   <= '0;
          if (in_valid) begin
            state      <= ST_PRE;
            cfg_rmii   <= rmii_mode;
            cfg_slow   <= rmii_mode && !speed_100;
            cfg_crc    <= crc_en;
            pre_cnt    <= '0;
            fcs_cnt    <= '0;
            last_seen  <= 1'b0;
            underrun_q <= 1'b0;
          end
        end
        ST_PRE, ST_SFD, ST_DATA, ST_FCS: begin
          if (tick) begin
            txd_q   <= sym;
            tx_en_q <= 1'b1;
            if (at_last) begin
              case (state)
                ST_PRE: begin
                  pre_cnt <= pre_cnt + 1'b1;
                  if (pre_cnt == PRE_LAST) state <= ST_SFD;
                end
                ST_FCS: begin
                  if (fcs_cnt == FCS_LAST) state <= ST_DONE;
                  else                     fcs_cnt <= fcs_cnt + 2'd1;
                end
                default: begin
                  if (state == ST_DATA && last_seen) begin
                    state <= cfg_crc ? ST_FCS : ST_DONE;
                  end else if (in_valid) begin
                    state     <= ST_DATA;
                    last_seen <= in_last;
                  end else begin
                    state      <= ST_FLUSH;
                    tx_en_q    <= 1'b0;
                    txd_q      <= '0;
                    underrun_q <= 1'b1;
                  end
                end
              endcase
            end
          end
        end
        ST_DONE: begin
          if (tick) begin
            tx_en_q <= 1'b0;
            txd_q   <= '0;
            state   <= ST_IDLE;
          end
        end
        ST_FLUSH: begin
          if (in_valid && in_last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign txd      = txd_q;
  assign tx_en    = tx_en_q;
  assign underrun = underrun_q;

  AST_RMII_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rmii |-> (txd[3:2] == 2'b00)); // R3

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(tx_en) && $stable(txd))); // R5

  AST_READY_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (state == ST_SFD || state == ST_DATA || state == ST_FLUSH)); // R6

  AST_UNDERRUN_KILLS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> !tx_en); // R7

  AST_FCS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FCS) |-> cfg_crc); // R4

  AST_CFG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> ($stable(cfg_rmii) && $stable(cfg_slow) && $stable(cfg_crc))); // R9

endmodule

// File: tb/eth_tx_framer_test.sv
module eth_tx_framer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic       crc_en = 1'b0;
  logic       rmii_mode = 1'b0;
  logic       speed_100 = 1'b1;
  logic [3:0] txd;
  logic       tx_en;
  logic       underrun;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  eth_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .crc_en(crc_en),
    .rmii_mode(rmii_mode), .speed_100(speed_100), .txd(txd),
    .tx_en(tx_en), .underrun(underrun)
  );

  // {rmii, speed_100, crc, 5'b0, len, seed, gap_before (FF = none)}
  localparam logic [31:0] VECS [8] = '{
    {3'b011, 5'd0, 8'd5, 8'h01, 8'hFF},
    {3'b110, 5'd0, 8'd6, 8'h33, 8'd2},
    {3'b000, 5'd0, 8'd3, 8'h40, 8'hFF},
    {3'b011, 5'd0, 8'd4, 8'h55, 8'd1},
    {3'b111, 5'd0, 8'd4, 8'h80, 8'hFF},
    {3'b101, 5'd0, 8'd3, 8'h77, 8'd1},
    {3'b101, 5'd0, 8'd2, 8'hA0, 8'hFF},
    {3'b011, 5'd0, 8'd1, 8'h11, 8'hFF}
  };

  logic [7:0] pay [0:63];
  logic [3:0] syms [0:1023];
  logic [7:0] eb [0:79];
  int hi_cycles;
  int ready_hits;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] fcs_model(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        c = (c[0] ^ pay[i][b]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return ~c;
  endfunction

  task automatic send_frame(input int len, input int gap_at);
    bit acc;
    for (int i = 0; i < len; i++) begin
      if (i == gap_at) begin
        in_valid = 1'b0;
        do @(negedge clk); while (!underrun);
      end
      in_valid = 1'b1;
      in_data  = pay[i];
      in_last  = (i == len - 1);
      do begin
        @(negedge clk);
        acc = in_ready;
        @(posedge clk);
        #1;
      end while (!acc);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic monitor(input int p);
    int k = 0;
    while (!tx_en) @(negedge clk);
    while (tx_en) begin
      if (k % p == 0) syms[k / p] = txd;
      k++;
      @(negedge clk);
    end
    hi_cycles = k;
  endtask

  task automatic run_core(input bit rmii, input bit spd, input bit crc,
                          input int len, input int gap_at, input bit flip,
                          input string tag);
    int p   = (rmii && !spd) ? 10 : 1;
    int spb = rmii ? 4 : 2;
    int ne = 0, exp_nsym, got_nsym, bad = 0, first_bad = -1;
    int nd = (gap_at >= 0) ? gap_at : len;
    logic [31:0] f;
    logic [3:0] es;
    rmii_mode = rmii; speed_100 = spd; crc_en = crc;
    ready_hits = 0;
    fork
      send_frame(len, gap_at);
      monitor(p);
      begin
        while (!tx_en) @(negedge clk);
        for (int c = 0; c < 12; c++) begin
          if (in_ready) ready_hits++;
          @(negedge clk);
        end
      end
      if (flip) begin
        while (!tx_en) @(negedge clk);
        repeat (6) @(negedge clk);
        rmii_mode = !rmii; speed_100 = !spd; crc_en = !crc;
      end
    join
    for (int i = 0; i < 7; i++) eb[ne++] = 8'h55;
    eb[ne++] = 8'hD5;
    for (int i = 0; i < nd; i++) eb[ne++] = pay[i];
    if (gap_at < 0 && crc) begin
      f = fcs_model(len);
      for (int i = 0; i < 4; i++) eb[ne++] = f[8*i +: 8];
    end
    exp_nsym = (gap_at >= 0) ? (8 + gap_at) * spb - 1 : ne * spb;
    got_nsym = (hi_cycles + p - 1) / p;
    check(hi_cycles == exp_nsym * p, "R5", {tag, " tx_en high cycles"},
          hi_cycles, exp_nsym * p);
    for (int k = 0; k < exp_nsym && k < got_nsym; k++) begin
      es = rmii ? 4'((eb[k / 4] >> (2 * (k % 4))) & 8'h03)
                : 4'((eb[k / 2] >> (4 * (k % 2))) & 8'h0F);
      if (syms[k] !== es) begin
        bad++;
        if (first_bad < 0) first_bad = k;
      end
    end
    check(bad == 0, "R2/R3/R4", {tag, " mismatched symbols (first index)"},
          bad, 0);
    if (bad != 0) $display("     first bad symbol index %0d", first_bad);
    check(underrun == (gap_at >= 0), (gap_at >= 0) ? "R7/R8" : "R8",
          {tag, " underrun after frame"}, underrun, gap_at >= 0);
    repeat (3) @(negedge clk);
    check(!in_ready && !tx_en, "R6/R8", {tag, " idle after frame"},
          {in_ready, tx_en}, 0);
    rmii_mode = rmii; speed_100 = spd; crc_en = crc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(tx_en == 1'b0, "R1", "tx_en in reset", tx_en, 0);
    check(txd == 4'h0, "R1", "txd in reset", txd, 0);
    check(underrun == 1'b0, "R1", "underrun in reset", underrun, 0);
    check(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!tx_en && !in_ready, "R1", "idle after reset", {tx_en, in_ready}, 0);

    // vector table
    for (int v = 0; v < 8; v++) begin
      logic [31:0] w = VECS[v];
      int gap = (w[7:0] == 8'hFF) ? -1 : int'(w[7:0]);
      for (int i = 0; i < int'(w[23:16]); i++) pay[i] = w[15:8] + 8'(i * 29);
      run_core(w[31], w[30], w[29], int'(w[23:16]), gap, 1'b0, $sformatf("vec%0d", v));
    end

    // R4, R6: known FCS check value, no ready during preamble
    for (int i = 0; i < 9; i++) pay[i] = 8'h31 + 8'(i);
    run_core(1'b0, 1'b1, 1'b1, 9, -1, 1'b0, "crc_check");
    check(ready_hits == 0, "R6", "in_ready during preamble", ready_hits, 0);
    begin
      logic [31:0] got;
      for (int b = 0; b < 4; b++)
        got[8*b +: 8] = {syms[2*(17+b)+1], syms[2*(17+b)]};
      check(got == 32'hCBF43926, "R4", "FCS of 123456789", got, 32'hCBF43926);
    end

    // R9: configuration flipped mid-frame, in slow and fast setups
    for (int i = 0; i < 5; i++) pay[i] = 8'hC3 ^ 8'(i * 17);
    run_core(1'b1, 1'b1, 1'b1, 5, -1, 1'b1, "R9_flip_rmii100");
    run_core(1'b1, 1'b0, 1'b0, 3, -1, 1'b1, "R9_flip_rmii10");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule